// File: doc/BRIEF.md
# Pseudo-Associative Read Cache

This block is a read-only cache of one-word lines kept in a single direct-mapped array. It gives most of the conflict tolerance of a two-way cache while keeping the one-comparison hit path of a direct-mapped design. Each request first looks at its home slot, which is selected by the low address bits. If the home slot does not hold the block, the block's partner slot is examined on the next cycle. The partner slot's index is the home index with its top bit inverted.

A block found in its partner slot is returned one cycle later than a home-slot hit. The two slots then trade contents, so a repeat access to that block becomes a fast hit. If neither slot holds the block, the word is fetched over the memory port and written into the home slot. A valid line that was in the home slot is pushed into the partner slot. Every response is marked with exactly one of three outcome pulses (fast hit, slow pseudo-hit, miss), and a performance counter or testbench can tally these.

Each slot stores a key made of the address bits above the index plus the top index bit. A block sitting in its partner slot can therefore never be confused with the block whose home that slot is.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset every slot is empty: `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the first access to any address is reported as a miss.
- R2: An access whose block is in its home slot (index = `req_addr[IDX_W-1:0]`) responds with `rsp_hit`=1 and the stored word in the cycle right after the request is accepted, with no memory request.
- R3: An access that misses its home slot then probes the partner slot, whose index is the home index with bit IDX_W-1 inverted. If the block is there, the response carries `rsp_pseudo_hit`=1 and the stored word two cycles after acceptance, with no memory request.
- R4: After a pseudo-hit the two slots have exchanged contents: the next access to the same block is a fast hit, and the line that was in the home slot now answers as a pseudo-hit.
- R5: When both probes miss, `mem_req_valid` rises two cycles after acceptance and holds `mem_req_addr` equal to the request address until `mem_rsp_valid` is sampled. The response, with `rsp_miss`=1 and `mem_rsp_data`, appears in the cycle after that.
- R6: A refilled block is written into its home slot. A valid line previously in the home slot moves to the partner slot, and whatever the partner slot held before is discarded.
- R7: The stored key includes the top index bit, so two blocks whose addresses differ only in that bit are distinct: neither is ever returned for the other, and both can be resident at once.
- R8: Every cycle with `rsp_valid`=1 carries exactly one of `rsp_hit`, `rsp_pseudo_hit`, `rsp_miss`. None of the three is high when `rsp_valid` is 0.
- R9: `req_ready` is 0 from the cycle after an access that misses its home slot is accepted until its response cycle, and it is 1 in the response cycle and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_data | output | DATA_W | Returned word |
| rsp_hit | output | 1 | Response came from the home slot |
| rsp_pseudo_hit | output | 1 | Response came from the partner slot |
| rsp_miss | output | 1 | Response came from memory |
| mem_req_valid | output | 1 | Refill request, held until answered |
| mem_req_addr | output | ADDR_W | Word address to fetch |
| mem_rsp_valid | input | 1 | Refill word present (one cycle) |
| mem_rsp_data | input | DATA_W | Refill word |

## Verification
The slot writes of a completed access (the pseudo-hit exchange or the refill and push-down) land on the same clock edge that delivers its response. The very next request can be accepted and probed in that response cycle. The bench provokes this overlap by presenting a new request in the exact cycle a response is visible: the same block right after a pseudo-hit or a refill, and the displaced partner right after a fast hit. It judges the second access by its outcome flag, its data and its latency. A fast hit one cycle after acceptance proves the second probe saw the freshly written slots rather than stale contents.

// File: rtl/pac_pkg.sv
package pac_pkg;

    // Controller phases of one access.
    typedef enum logic [1:0] {
        PAC_IDLE = 2'd0,   // waiting; home slot probed combinationally
        PAC_ALT  = 2'd1,   // partner slot probe
        PAC_FILL = 2'd2    // waiting for the refill word
    } pac_state_e;

    // Outcome attached to a response.
    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_HIT    = 2'd1,
        KIND_PSEUDO = 2'd2,
        KIND_MISS   = 2'd3
    } pac_kind_e;

endpackage

// File: rtl/pac_match.sv
module pac_match #(
    parameter int KEY_W = 10
) (
    input  logic             line_valid,
    input  logic [KEY_W-1:0] line_key,
    input  logic [KEY_W-1:0] want_key,
    output logic             hit
);

    assign hit = line_valid && (line_key == want_key);

endmodule

// File: rtl/pac_line_store.sv
module pac_line_store #(
    parameter int IDX_W  = 3,
    parameter int KEY_W  = 10,
    parameter int DATA_W = 32,
    parameter int NPORT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  port_idx   [NPORT],
    output logic              rd_valid   [NPORT],
    output logic [KEY_W-1:0]  rd_key     [NPORT],
    output logic [DATA_W-1:0] rd_data    [NPORT],
    input  logic              wr_en      [NPORT],
    input  logic              wr_valid   [NPORT],
    input  logic [KEY_W-1:0]  wr_key     [NPORT],
    input  logic [DATA_W-1:0] wr_data    [NPORT]
);

    localparam int LINES = 1 << IDX_W;

    logic              valid_q [LINES];
    logic              valid_d [LINES];
    logic [KEY_W-1:0]  key_q   [LINES];
    logic [KEY_W-1:0]  key_d   [LINES];
    logic [DATA_W-1:0] data_q  [LINES];
    logic [DATA_W-1:0] data_d  [LINES];

    // Asynchronous read ports, one per probe.
    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rd_valid[p] = valid_q[port_idx[p]];
        assign rd_key[p]   = key_q[port_idx[p]];
        assign rd_data[p]  = data_q[port_idx[p]];
    end

    // Ports always address different slots, so write order is irrelevant.
    always_comb begin
        valid_d = valid_q;
        key_d   = key_q;
        data_d  = data_q;
        for (int p = 0; p < NPORT; p++) begin
            if (wr_en[p]) begin
                valid_d[port_idx[p]] = wr_valid[p];
                key_d[port_idx[p]]   = wr_key[p];
                data_d[port_idx[p]]  = wr_data[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= 1'b0;
                key_q[i]   <= '0;
                data_q[i]  <= '0;
            end
        end else begin
            valid_q <= valid_d;
            key_q   <= key_d;
            data_q  <= data_d;
        end
    end

endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
    import pac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    output logic [IDX_W-1:0]    prim_idx,
    output logic [IDX_W-1:0]    alt_idx,
    output logic [ADDR_W-IDX_W:0] want_key,
    input  logic                prim_hit,
    input  logic                alt_hit,
    input  logic                prim_valid,
    input  logic [ADDR_W-IDX_W:0] prim_key,
    input  logic [DATA_W-1:0]   prim_data,
    input  logic                alt_valid,
    input  logic [ADDR_W-IDX_W:0] alt_key,
    input  logic [DATA_W-1:0]   alt_data,
    output logic                prim_we,
    output logic                prim_wvalid,
    output logic [ADDR_W-IDX_W:0] prim_wkey,
    output logic [DATA_W-1:0]   prim_wdata,
    output logic                alt_we,
    output logic                alt_wvalid,
    output logic [ADDR_W-IDX_W:0] alt_wkey,
    output logic [DATA_W-1:0]   alt_wdata,
    output logic                mem_req_valid,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_data,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output pac_kind_e           rsp_kind
);

    localparam logic [IDX_W-1:0] FLIP_MASK = IDX_W'(1) << (IDX_W - 1);

    typedef struct packed {
        pac_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        pac_kind_e         kind;
    } ctrl_t;

    ctrl_t q, d;
    logic [ADDR_W-1:0] cur_addr;

    // While idle the incoming address drives the probe; later the latched one.
    assign cur_addr  = (q.st == PAC_IDLE) ? req_addr : q.addr;
    assign prim_idx  = cur_addr[IDX_W-1:0];
    assign alt_idx   = prim_idx ^ FLIP_MASK;
    assign want_key  = cur_addr[ADDR_W-1:IDX_W-1];

    always_comb begin
        d             = q;
        d.rsp_valid   = 1'b0;
        d.kind        = KIND_NONE;
        prim_we       = 1'b0;
        prim_wvalid   = alt_valid;
        prim_wkey     = alt_key;
        prim_wdata    = alt_data;
        alt_we        = 1'b0;
        alt_wvalid    = prim_valid;
        alt_wkey      = prim_key;
        alt_wdata     = prim_data;
        case (q.st)
            PAC_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    if (prim_hit) begin
                        d.rsp_valid = 1'b1;
                        d.rsp_data  = prim_data;
                        d.kind      = KIND_HIT;
                    end else begin
                        d.st = PAC_ALT;
                    end
                end
            end
            PAC_ALT: begin
                if (alt_hit) begin
                    // exchange the two slots
                    prim_we     = 1'b1;
                    alt_we      = 1'b1;
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = alt_data;
                    d.kind      = KIND_PSEUDO;
                    d.st        = PAC_IDLE;
                end else begin
                    d.st = PAC_FILL;
                end
            end
            PAC_FILL: begin
                if (mem_rsp_valid) begin
                    prim_we     = 1'b1;
                    prim_wvalid = 1'b1;
                    prim_wkey   = want_key;
                    prim_wdata  = mem_rsp_data;
                    alt_we      = prim_valid;  // push down only a live line
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = mem_rsp_data;
                    d.kind      = KIND_MISS;
                    d.st        = PAC_IDLE;
                end
            end
            default: d.st = PAC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: PAC_IDLE, addr: '0, rsp_valid: 1'b0,
                   rsp_data: '0, kind: KIND_NONE};
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == PAC_IDLE);
    assign mem_req_valid = (q.st == PAC_FILL);
    assign mem_req_addr  = q.addr;
    assign rsp_valid     = q.rsp_valid;
    assign rsp_data      = q.rsp_data;
    assign rsp_kind      = q.kind;

endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
    import pac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_hit,
    output logic              rsp_pseudo_hit,
    output logic              rsp_miss,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    localparam int KEY_W  = ADDR_W - IDX_W + 1;
    localparam int NPROBE = 2;   // port 0: home slot, port 1: partner slot

    logic [IDX_W-1:0]  prim_idx, alt_idx;
    logic [KEY_W-1:0]  want_key;
    logic [IDX_W-1:0]  st_idx    [NPROBE];
    logic              st_valid  [NPROBE];
    logic [KEY_W-1:0]  st_key    [NPROBE];
    logic [DATA_W-1:0] st_data   [NPROBE];
    logic              st_we     [NPROBE];
    logic              st_wvalid [NPROBE];
    logic [KEY_W-1:0]  st_wkey   [NPROBE];
    logic [DATA_W-1:0] st_wdata  [NPROBE];
    logic [NPROBE-1:0] probe_hit;
    pac_kind_e         kind;

    assign st_idx[0] = prim_idx;
    assign st_idx[1] = alt_idx;

    pac_line_store #(
        .IDX_W (IDX_W),
        .KEY_W (KEY_W),
        .DATA_W(DATA_W),
        .NPORT (NPROBE)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_idx(st_idx),
        .rd_valid(st_valid),
        .rd_key  (st_key),
        .rd_data (st_data),
        .wr_en   (st_we),
        .wr_valid(st_wvalid),
        .wr_key  (st_wkey),
        .wr_data (st_wdata)
    );

    for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        pac_match #(.KEY_W(KEY_W)) u_match (
            .line_valid(st_valid[p]),
            .line_key  (st_key[p]),
            .want_key  (want_key),
            .hit       (probe_hit[p])
        );
    end

    pac_ctrl #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_ready    (req_ready),
        .prim_idx     (prim_idx),
        .alt_idx      (alt_idx),
        .want_key     (want_key),
        .prim_hit     (probe_hit[0]),
        .alt_hit      (probe_hit[1]),
        .prim_valid   (st_valid[0]),
        .prim_key     (st_key[0]),
        .prim_data    (st_data[0]),
        .alt_valid    (st_valid[1]),
        .alt_key      (st_key[1]),
        .alt_data     (st_data[1]),
        .prim_we      (st_we[0]),
        .prim_wvalid  (st_wvalid[0]),
        .prim_wkey    (st_wkey[0]),
        .prim_wdata   (st_wdata[0]),
        .alt_we       (st_we[1]),
        .alt_wvalid   (st_wvalid[1]),
        .alt_wkey     (st_wkey[1]),
        .alt_wdata    (st_wdata[1]),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_kind     (kind)
    );

    assign rsp_hit        = (kind == KIND_HIT);
    assign rsp_pseudo_hit = (kind == KIND_PSEUDO);
    assign rsp_miss       = (kind == KIND_MISS);

endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_pseudo_hit,
    input logic              rsp_miss,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid
);

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_pseudo_hit, rsp_miss}) == 1); // R8

    AST_QUIET_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_hit, rsp_pseudo_hit, rsp_miss} == 3'b000)); // R8

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(req_valid && req_ready)); // R2

    AST_PSEUDO_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pseudo_hit |-> ($past(req_valid && req_ready, 2) && !$past(req_ready))); // R3

    AST_MISS_AFTER_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> $past(mem_req_valid && mem_rsp_valid)); // R5

    AST_REFILL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $past(mem_req_valid)) |-> $stable(mem_req_addr)); // R5

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R9

    AST_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R9

endmodule

bind pseudo_assoc_cache pac_checker #(.ADDR_W(ADDR_W)) u_pac_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_pseudo_hit(rsp_pseudo_hit),
    .rsp_miss      (rsp_miss),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_pseudo_assoc_cache.sv
`timescale 1ns/1ps
module tb_pseudo_assoc_cache;

    localparam int ADDR_W  = 12;
    localparam int IDX_W   = 3;
    localparam int DATA_W  = 32;
    localparam int MEM_LAT = 2;

    localparam logic [2:0] K_HIT  = 3'b001;
    localparam logic [2:0] K_PSH  = 3'b010;
    localparam logic [2:0] K_MISS = 3'b100;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_hit, rsp_pseudo_hit, rsp_miss;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid;
    logic [DATA_W-1:0] mem_rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    int mem_reqs = 0;
    logic [ADDR_W-1:0] last_mem_addr = '0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pseudo_assoc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_hit(rsp_hit), .rsp_pseudo_hit(rsp_pseudo_hit), .rsp_miss(rsp_miss),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a ^ 12'h5A3, 8'hC3, a};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: answers MEM_LAT cycles after it first sees a request.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                mem_reqs++;
                last_mem_addr = mem_req_addr;
                repeat (MEM_LAT) @(negedge clk);
                mem_rsp_data  = mem_word(mem_req_addr);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Waits for the response of an accepted access and judges it.
    task automatic wait_and_check(input logic [ADDR_W-1:0] a, input logic [2:0] kind,
                                  input int reqs0, input string req);
        int cyc;
        int lat;
        req_valid = 1'b0;
        cyc = 1;
        if (kind != K_HIT) chk("R9", "ready low while busy", 32'(req_ready), 32'd0);
        while (!rsp_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        lat = (kind == K_HIT) ? 1 : (kind == K_PSH) ? 2 : 3 + MEM_LAT;
        chk(req, "outcome {miss,pseudo,hit}",
            32'({rsp_miss, rsp_pseudo_hit, rsp_hit}), 32'(kind));
        chk(req, "data", rsp_data, mem_word(a));
        chk(req, "latency", 32'(cyc), 32'(lat));
        chk(req, "memory requests", 32'(mem_reqs - reqs0), (kind == K_MISS) ? 32'd1 : 32'd0);
        if (kind == K_MISS) chk("R5", "refill address", 32'(last_mem_addr), 32'(a));
        chk("R9", "ready in response cycle", 32'(req_ready), 32'd1);
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic [2:0] kind,
                          input string req);
        int reqs0;
        @(negedge clk);
        reqs0 = mem_reqs;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        wait_and_check(a, kind, reqs0, req);
    endtask

    // Second request presented in the very cycle the first response is visible.
    task automatic back_to_back(input logic [ADDR_W-1:0] a, input logic [2:0] ka,
                                input logic [ADDR_W-1:0] b, input logic [2:0] kb,
                                input string req);
        int reqs0;
        @(negedge clk);
        reqs0 = mem_reqs;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        wait_and_check(a, ka, reqs0, req);
        reqs0 = mem_reqs;
        req_valid = 1'b1;
        req_addr  = b;
        @(negedge clk);
        wait_and_check(b, kb, reqs0, req);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", 32'(req_ready), 32'd1);
        chk("R1", "no response after reset", 32'(rsp_valid), 32'd0);
        chk("R1", "no refill after reset", 32'(mem_req_valid), 32'd0);
    endtask

    // Home hits, pseudo-hits and the exchange (index bit 2 is the flipped bit).
    task automatic t_basic;
        access(12'h010, K_MISS, "R1");   // empty cache
        access(12'h010, K_HIT,  "R2");
        access(12'h020, K_MISS, "R5");   // 020 home slot 0, 010 pushed to slot 4
        access(12'h010, K_PSH,  "R3");   // found in partner slot 4
        access(12'h010, K_HIT,  "R4");   // exchanged into home
        access(12'h020, K_PSH,  "R4");   // displaced line now in partner slot
    endtask

    // Refill placement and loss of the old partner content.
    task automatic t_refill;
        access(12'h030, K_MISS, "R6");   // slot0=030, slot4=020, 010 dropped
        access(12'h010, K_MISS, "R6");   // slot0=010, slot4=030
        access(12'h030, K_PSH,  "R6");   // slot0=030, slot4=010
        access(12'h020, K_MISS, "R6");   // slot0=020, slot4=030
        access(12'h010, K_MISS, "R6");
    endtask

    // Blocks differing only in the top index bit must stay distinct.
    task automatic t_key;
        access(12'h012, K_MISS, "R7");   // slot 2
        access(12'h016, K_MISS, "R7");   // slot 6, partner slot 2 must not match
        access(12'h012, K_HIT,  "R7");
        access(12'h016, K_HIT,  "R7");
    endtask

    // Response cycle overlaps with acceptance of the next request.
    task automatic t_overlap;
        access(12'h041, K_MISS, "R5");
        access(12'h051, K_MISS, "R6");              // slot1=051, slot5=041
        back_to_back(12'h041, K_PSH, 12'h041, K_HIT, "R4");
        back_to_back(12'h041, K_HIT, 12'h051, K_PSH, "R3");
        back_to_back(12'h051, K_HIT, 12'h041, K_PSH, "R4");
        back_to_back(12'h077, K_MISS, 12'h077, K_HIT, "R2");
        access(12'h0AA, K_MISS, "R8");
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_basic();
        t_refill();
        t_key();
        t_overlap();
        repeat (3) @(negedge clk);
        summary();
    end

endmodule